// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block arbitrates six interrupt sources for an 8-bit microcontroller core. Software writes one enable register and two priority registers through a byte-wide special-function-register port. The two priority bits of each source combine into one of four levels. The controller raises one registered request with a vector address. It keeps the request steady until the core acknowledges it.

On acknowledge the granted level enters a four-bit in-service mask. While it is in service, only a strictly higher level can interrupt it. A return-from-interrupt pulse retires the most recent level, so a pre-empted lower handler resumes where it stopped. On acknowledge the block also pulses a hardware-clear strobe for the source flags that clear automatically. These are timer 0, timer 1, and external inputs set to transition mode. The peripherals, the pin synchronisers and the core are outside this block.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Register map. The enable register is at A8H: bit 7 is the global enable, bit 6 always reads 0, and bits 5..0 enable the sources in index order. The source indices are 0 ext0, 1 tmr0, 2 ext1, 3 tmr1, 4 serial, 5 tmr2. The low priority register is at B8H and the high priority register is at B7H. Each uses bits 5..0 in the same index order, and its bits 7..6 read 0. Reads are combinational on `sfr_addr_i`, and an unmapped address reads 00H.
- R2: When the global enable bit is 0 no request is raised. A source whose own enable bit is 0 never requests.
- R3: A source's level is {high bit, low bit}, from 0 (lowest) to 3 (highest). The eligible source with the highest level wins.
- R4: Among eligible sources of equal highest level, the lowest index wins.
- R5: The vector is 03H + 8 × index: 03H, 0BH, 13H, 1BH, 23H, 2BH.
- R6: In `flag_i`, bits 0..3 are the ext0, tmr0, ext1 and tmr1 flags. Bits 4 and 5 are the serial receive and transmit flags, and the serial source requests if either is set. Bits 6 and 7 are the two timer 2 flags, and timer 2 requests if either is set.
- R7: A source is eligible only if nothing is in service, or if its level is strictly greater than the highest in-service level.
- R8: An acknowledge of a raised request sets the in-service bit of the granted level. A `reti_i` pulse clears the highest set in-service bit.
- R9: While `irq_req_o` is high and not acknowledged, `irq_vec_o` holds its value, even if a higher request arrives.
- R10: If the latched source's enable bit or the global enable is cleared, `irq_req_o` drops in the cycle after the register write.
- R11: One cycle after acknowledge, `hw_clr_o` pulses one bit: bit 0 ext0, bit 1 tmr0, bit 2 ext1, bit 3 tmr1. Timers 0 and 1 always pulse. An external source pulses only if its `ext_edge_i` bit (bit 0 ext0, bit 1 ext1) is 1. Serial and timer 2 never pulse.
- R12: After reset all registers and the in-service mask are 0, and `irq_req_o` and `hw_clr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sfr_addr_i | input | 8 | SFR address |
| sfr_wr_i | input | 1 | SFR write strobe |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data |
| flag_i | input | 8 | Raw request flags from the peripherals |
| ext_edge_i | input | 2 | External input transition mode (1 = edge) |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 8 | Vector address |
| irq_ack_i | input | 1 | Core acknowledge |
| reti_i | input | 1 | Return-from-interrupt pulse |
| hw_clr_o | output | 4 | Hardware flag-clear strobes |

## Verification
The assertions check four things on every cycle. The vector holds steady while a request waits. A raised request always lies above the highest in-service level. The in-service mask gains a bit only on an acknowledge, and a return pulse removes exactly one bit. The clear strobes are one-hot at most and only follow an acknowledge. The bench scenarios cover the rest. These are the level encoding, the polling tie-break, the vector values, and the serial and timer 2 flag merging. They also cover withdrawal after an enable write, which flags are cleared in each external-input mode, and a nested sequence in which a pre-empted level request resumes after a return.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NUM_SRC  = 6;
  localparam int NUM_LVL  = 4;
  localparam int LVL_W    = $clog2(NUM_LVL);
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int DATA_W   = 8;
  localparam int FLAG_W   = 8;
  localparam int NUM_CLR  = 4;
  localparam logic [DATA_W-1:0] VEC_BASE = 8'h03;
  localparam int VEC_STEP_SH = 3;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/irq_sfr_regs.sv
module irq_sfr_regs
  import irq_nest_pkg::*;
#(
  parameter int              NSRC  = NUM_SRC,
  parameter logic [7:0]      A_EN  = 8'hA8,
  parameter logic [7:0]      A_PLO = 8'hB8,
  parameter logic [7:0]      A_PHI = 8'hB7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ea_o,
  output logic [NSRC-1:0]   en_o,
  output logic [NSRC-1:0]   plo_o,
  output logic [NSRC-1:0]   phi_o
);
  localparam int GEN_BIT = DATA_W - 1;
  localparam int PAD_W   = DATA_W - NSRC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_o  <= 1'b0;
      en_o  <= '0;
      plo_o <= '0;
      phi_o <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        A_EN: begin
          ea_o <= wdata_i[GEN_BIT];
          en_o <= wdata_i[NSRC-1:0];
        end
        A_PLO:   plo_o <= wdata_i[NSRC-1:0];
        A_PHI:   phi_o <= wdata_i[NSRC-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_EN: begin
        rdata_o[NSRC-1:0] = en_o;
        rdata_o[GEN_BIT]  = ea_o;
      end
      A_PLO:   rdata_o = {{PAD_W{1'b0}}, plo_o};
      A_PHI:   rdata_o = {{PAD_W{1'b0}}, phi_o};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_nest_pkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            ea_i,
  input  logic [NSRC-1:0] plo_i,
  input  logic [NSRC-1:0] phi_i,
  input  logic            busy_i,
  input  lvl_t            busy_lvl_i,
  output logic            win_o,
  output idx_t            win_idx_o,
  output lvl_t            win_lvl_o
);
  lvl_t            lvl [NSRC];
  logic [NSRC-1:0] elig;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign lvl[s]  = {phi_i[s], plo_i[s]};
    assign elig[s] = pend_i[s] & en_i[s] & ea_i & (!busy_i || (lvl[s] > busy_lvl_i));
  end

  // strict '>' keeps the lowest index on a level tie
  always_comb begin
    win_o     = 1'b0;
    win_idx_o = '0;
    win_lvl_o = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (elig[s] && (!win_o || lvl[s] > win_lvl_o)) begin
        win_o     = 1'b1;
        win_idx_o = idx_t'(s);
        win_lvl_o = lvl[s];
      end
    end
  end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
  import irq_nest_pkg::*;
#(
  parameter int NLVL = NUM_LVL
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  lvl_t            set_lvl_i,
  input  logic            reti_i,
  output logic [NLVL-1:0] mask_o,
  output logic            any_o,
  output lvl_t            top_o
);
  logic [NLVL-1:0] mask_d;

  always_comb begin
    top_o = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (mask_o[l]) top_o = lvl_t'(l);
    end
  end
  assign any_o = |mask_o;

  always_comb begin
    mask_d = mask_o;
    if (reti_i && any_o) mask_d[top_o] = 1'b0;
    if (set_i) mask_d[set_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else         mask_o <= mask_d;
  end

  property p_set_needs_ack;
    @(posedge clk_i) disable iff (!rst_ni)
      !set_i |=> ((mask_o & ~$past(mask_o)) == '0);
  endproperty
  assert_set_needs_ack_R8: assert property (p_set_needs_ack);

  property p_reti_drops_one;
    @(posedge clk_i) disable iff (!rst_ni)
      (reti_i && any_o && !set_i) |=> ($countones(mask_o) == $countones($past(mask_o)) - 1);
  endproperty
  assert_reti_drops_one_R8: assert property (p_reti_drops_one);
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [7:0]         sfr_addr_i,
  input  logic               sfr_wr_i,
  input  logic [DATA_W-1:0]  sfr_wdata_i,
  output logic [DATA_W-1:0]  sfr_rdata_o,
  input  logic [FLAG_W-1:0]  flag_i,
  input  logic [1:0]         ext_edge_i,
  output logic               irq_req_o,
  output logic [DATA_W-1:0]  irq_vec_o,
  input  logic               irq_ack_i,
  input  logic               reti_i,
  output logic [NUM_CLR-1:0] hw_clr_o
);
  logic               ea;
  logic [NUM_SRC-1:0] en, plo, phi, pend;
  logic [NUM_LVL-1:0] is_mask;
  logic               is_any, win;
  lvl_t               is_top, win_lvl, lvl_q;
  idx_t               win_idx, idx_q;
  logic               req_q, live, grant;
  logic [NUM_CLR-1:0] clr_ok;

  irq_sfr_regs #(.NSRC(NUM_SRC)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(sfr_addr_i), .wr_i(sfr_wr_i), .wdata_i(sfr_wdata_i), .rdata_o(sfr_rdata_o),
    .ea_o(ea), .en_o(en), .plo_o(plo), .phi_o(phi)
  );

  // serial and timer 2 each merge two flags
  assign pend = {flag_i[7] | flag_i[6], flag_i[5] | flag_i[4], flag_i[3:0]};

  irq_arbiter #(.NSRC(NUM_SRC)) u_arb (
    .pend_i(pend), .en_i(en), .ea_i(ea), .plo_i(plo), .phi_i(phi),
    .busy_i(is_any), .busy_lvl_i(is_top),
    .win_o(win), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
  );

  assign live      = ea & en[idx_q];
  assign irq_req_o = req_q & live;
  assign grant     = irq_req_o & irq_ack_i;
  assign irq_vec_o = VEC_BASE + (DATA_W'(idx_q) << VEC_STEP_SH);

  irq_inservice #(.NLVL(NUM_LVL)) u_is (
    .clk_i, .rst_ni,
    .set_i(grant), .set_lvl_i(lvl_q), .reti_i,
    .mask_o(is_mask), .any_o(is_any), .top_o(is_top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      idx_q <= '0;
      lvl_q <= '0;
    end else if (req_q) begin
      if (grant || !live) req_q <= 1'b0;
    end else if (win) begin
      req_q <= 1'b1;
      idx_q <= win_idx;
      lvl_q <= win_lvl;
    end
  end

  assign clr_ok = {1'b1, ext_edge_i[1], 1'b1, ext_edge_i[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hw_clr_o <= '0;
    else begin
      hw_clr_o <= '0;
      for (int c = 0; c < NUM_CLR; c++) begin
        if (grant && idx_q == idx_t'(c) && clr_ok[c]) hw_clr_o[c] <= 1'b1;
      end
    end
  end

  property p_vec_stable;
    @(posedge clk_i) disable iff (!rst_ni)
      (irq_req_o && !irq_ack_i) |=> $stable(irq_vec_o);
  endproperty
  assert_vec_stable_R9: assert property (p_vec_stable);

  property p_above_inservice;
    @(posedge clk_i) disable iff (!rst_ni)
      irq_req_o |-> (!is_any || (lvl_q > is_top));
  endproperty
  assert_above_inservice_R7: assert property (p_above_inservice);

  property p_clr_onehot;
    @(posedge clk_i) disable iff (!rst_ni) $onehot0(hw_clr_o);
  endproperty
  assert_clr_onehot_R11: assert property (p_clr_onehot);

  property p_clr_after_ack;
    @(posedge clk_i) disable iff (!rst_ni)
      (|hw_clr_o) |-> $past(irq_req_o && irq_ack_i);
  endproperty
  assert_clr_after_ack_R11: assert property (p_clr_after_ack);
endmodule

// File: tb/tb_irq_nest_ctrl.sv
`timescale 1ns/1ps
module tb_irq_nest_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] sfr_addr_i = '0, sfr_wdata_i = '0, sfr_rdata_o;
  logic       sfr_wr_i = 1'b0;
  logic [7:0] flag_i = '0;
  logic [1:0] ext_edge_i = '0;
  logic       irq_req_o, irq_ack_i = 1'b0, reti_i = 1'b0;
  logic [7:0] irq_vec_o;
  logic [3:0] hw_clr_o;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_nest_ctrl dut (.*);

  localparam logic [7:0] A_EN = 8'hA8, A_PLO = 8'hB8, A_PHI = 8'hB7;

  typedef struct packed {
    logic [7:0] en, plo, phi, flg;
    logic       req;
    logic [7:0] vec;
  } row_t;

  localparam int N_ROW = 10;
  localparam row_t TBL [N_ROW] = '{
    '{8'hBF, 8'h00, 8'h00, 8'hFF, 1'b1, 8'h03},  // R3 R4 all level 0
    '{8'hBF, 8'h20, 8'h00, 8'hFF, 1'b1, 8'h2B},  // R3 tmr2 level 1
    '{8'hBF, 8'h3F, 8'h10, 8'hFF, 1'b1, 8'h23},  // R3 serial level 3
    '{8'hBF, 8'h02, 8'h08, 8'hFF, 1'b1, 8'h1B},  // R3 tmr1 lvl2 over tmr0 lvl1
    '{8'h3F, 8'h00, 8'h00, 8'hFF, 1'b0, 8'h00},  // R2 global off
    '{8'hBE, 8'h00, 8'h00, 8'h01, 1'b0, 8'h00},  // R2 ext0 disabled
    '{8'hB0, 8'h00, 8'h00, 8'h20, 1'b1, 8'h23},  // R6 transmit flag
    '{8'hA0, 8'h00, 8'h00, 8'h80, 1'b1, 8'h2B},  // R6 second timer 2 flag
    '{8'hBF, 8'h00, 8'h0C, 8'hFF, 1'b1, 8'h13},  // R4 tie at level 2
    '{8'hBF, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00}   // R2 nothing pending
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr_i = a; sfr_wdata_i = d; sfr_wr_i = 1'b1;
    step(1);
    sfr_wr_i = 1'b0;
  endtask

  task automatic ack();
    irq_ack_i = 1'b1; step(1); irq_ack_i = 1'b0;
  endtask

  task automatic reti();
    reti_i = 1'b1; step(1); reti_i = 1'b0;
  endtask

  task automatic do_reset();
    flag_i = '0; ext_edge_i = '0; irq_ack_i = 1'b0; reti_i = 1'b0; sfr_wr_i = 1'b0;
    rst_ni = 1'b0;
    step(2);
    rst_ni = 1'b1;
    step(1);
  endtask

  initial begin
    do_reset();
    // R12 reset state
    sfr_addr_i = A_EN; #1;
    chk("R12 enable reg", 32'(sfr_rdata_o), 32'h00);
    chk("R12 req", 32'(irq_req_o), 32'h0);
    chk("R12 clr", 32'(hw_clr_o), 32'h0);
    step(1);

    // R1 readback
    sfr_wr(A_EN, 8'hFF);  sfr_addr_i = A_EN;  #1; chk("R1 enable read", 32'(sfr_rdata_o), 32'hBF);
    step(1);
    sfr_wr(A_PLO, 8'hFF); sfr_addr_i = A_PLO; #1; chk("R1 low prio read", 32'(sfr_rdata_o), 32'h3F);
    step(1);
    sfr_wr(A_PHI, 8'hC5); sfr_addr_i = A_PHI; #1; chk("R1 high prio read", 32'(sfr_rdata_o), 32'h05);
    step(1);
    sfr_addr_i = 8'h90; #1; chk("R1 unmapped read", 32'(sfr_rdata_o), 32'h00);
    step(1);

    // table walk
    do_reset();
    for (int i = 0; i < N_ROW; i++) begin
      sfr_wr(A_EN, TBL[i].en);
      sfr_wr(A_PLO, TBL[i].plo);
      sfr_wr(A_PHI, TBL[i].phi);
      flag_i = TBL[i].flg;
      step(1);
      chk($sformatf("R2/R3/R4/R6 row %0d req", i), 32'(irq_req_o), 32'(TBL[i].req));
      if (TBL[i].req)
        chk($sformatf("R5 row %0d vec", i), 32'(irq_vec_o), 32'(TBL[i].vec));
      flag_i = '0;
      sfr_wr(A_EN, 8'h00);
      step(1);
    end

    // nesting sequence
    do_reset();
    ext_edge_i = 2'b01;
    sfr_wr(A_EN, 8'hBF);
    flag_i = 8'h01;
    step(1);
    chk("R5 ext0 req", 32'(irq_req_o), 32'h1);
    chk("R5 ext0 vec", 32'(irq_vec_o), 32'h03);
    flag_i = 8'h09;
    sfr_wr(A_PLO, 8'h08);  // tmr1 to level 1 while ext0 waits
    chk("R9 vec held", 32'(irq_vec_o), 32'h03);
    chk("R9 req held", 32'(irq_req_o), 32'h1);
    ack();
    flag_i = 8'h08;
    chk("R11 ext0 edge clear", 32'(hw_clr_o), 32'h1);
    chk("R8 req drops on ack", 32'(irq_req_o), 32'h0);
    step(1);
    chk("R7 preempt req", 32'(irq_req_o), 32'h1);
    chk("R7 preempt vec", 32'(irq_vec_o), 32'h1B);
    ack();
    flag_i = 8'h00;
    chk("R11 tmr1 clear", 32'(hw_clr_o), 32'h8);
    sfr_wr(A_PLO, 8'h0A);
    flag_i = 8'h02;
    step(2);
    chk("R7 equal level blocked", 32'(irq_req_o), 32'h0);
    reti();
    step(1);
    chk("R8 resumes after reti", 32'(irq_req_o), 32'h1);
    chk("R8 resume vec", 32'(irq_vec_o), 32'h0B);
    sfr_wr(A_EN, 8'hBD);
    chk("R10 source disable", 32'(irq_req_o), 32'h0);
    sfr_wr(A_EN, 8'hBF);
    step(1);
    chk("R10 re-request", 32'(irq_req_o), 32'h1);
    sfr_wr(A_EN, 8'h3F);
    chk("R10 global disable", 32'(irq_req_o), 32'h0);
    sfr_wr(A_EN, 8'hBF);
    step(1);
    ack();
    flag_i = 8'h00;
    chk("R11 tmr0 clear", 32'(hw_clr_o), 32'h2);
    sfr_wr(A_PLO, 8'h10);
    flag_i = 8'h10;
    step(2);
    chk("R7 serial blocked", 32'(irq_req_o), 32'h0);
    reti();
    step(1);
    chk("R6 serial req", 32'(irq_req_o), 32'h1);
    chk("R5 serial vec", 32'(irq_vec_o), 32'h23);
    ack();
    chk("R11 serial no clear", 32'(hw_clr_o), 32'h0);
    flag_i = 8'h00;
    reti();
    reti();
    // ext1 level mode
    ext_edge_i = 2'b00;
    sfr_wr(A_PLO, 8'h00);
    flag_i = 8'h04;
    step(1);
    chk("R5 ext1 vec", 32'(irq_vec_o), 32'h13);
    ack();
    chk("R11 ext1 level no clear", 32'(hw_clr_o), 32'h0);
    ext_edge_i = 2'b10;
    reti();
    step(1);
    chk("R8 ext1 again", 32'(irq_req_o), 32'h1);
    ack();
    chk("R11 ext1 edge clear", 32'(hw_clr_o), 32'h4);
    flag_i = 8'h00;
    reti();
    step(2);
    chk("R8 idle after retire", 32'(irq_req_o), 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule